// File: doc/BRIEF.md
# Hold-and-Modify Pixel Color Decoder

This block turns the bitplane value of each pixel into a 24-bit RGB word. In indexed operation the plane value selects an entry of an internal palette register file. In hold-and-modify operation the two top plane bits form a control code. That code either selects a palette entry or copies the previous pixel's color and replaces one channel with the low plane bits. A sharp color edge therefore needs several pixels to settle, and this fringing is reproduced exactly.

Two depths are supported. A narrow 6-plane mode works in a 12-bit color space with 4 bits per channel. A wide 8-plane mode works with 6 bits per channel, 18 bits in all, and keeps the two low bits of a modified 8-bit channel. A line-start strobe that comes with the first pixel of a line makes that pixel treat palette entry 0 as its predecessor, so no color leaks from the previous line. Software or a sequencer loads the palette through a simple write port. Bitplane fetch, serialization and video timing sit outside the block.

Top module: `ham_pixel_decoder`

## Requirements
- R1: After reset, out_valid is 0, out_rgb is 0, and every palette entry reads as 0.
- R2: out_valid is pix_valid delayed by one clock. out_rgb changes only in the cycle after a valid pixel and otherwise holds its value.
- R3: With ham_en=0, the pixel's color is a plain palette lookup. In wide mode the index is all of planes[7:0]. In narrow mode the index is planes[4:0], with planes[7:5] ignored, and each 8-bit channel is output as its upper nibble repeated twice ({n,n}).
- R4: With ham_en=1 and control code 00, the pixel's color is a palette lookup. In narrow mode the index is planes[3:0] and the result is nibble-repeated as in R3. In wide mode the index is planes[5:0].
- R5: In narrow hold-and-modify mode the control code is planes[5:4]: 01 modifies blue, 10 modifies red and 11 modifies green. The selected channel becomes {d,d} with d=planes[3:0]. The other two channels keep their values from the previous pixel, nibble-repeated.
- R6: In wide hold-and-modify mode the control code is planes[7:6], with the same channel codes as R5. planes[5:0] replaces bits [7:2] of the selected channel, and bits [1:0] of that channel and the other two channels keep their values from the previous pixel.
- R7: When line_start is high together with pix_valid, palette entry 0 stands in for the previous pixel's color. In narrow mode it is nibble-repeated.
- R8: A palette write in one cycle is seen by a pixel in the next cycle and later, but not by a pixel in the same cycle.
- R9: Cycles without pix_valid leave the held color unchanged. A modify pixel after a gap uses the last valid pixel's color.
- R10: Every output produced from a narrow-mode pixel has each channel in the form {n,n}.
- Color words are packed as R in [23:16], G in [15:8] and B in [7:0], for both out_rgb and pal_wr_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1 = 8-plane mode, 0 = 6-plane mode |
| ham_en | input | 1 | 1 = hold-and-modify, 0 = plain indexed |
| pix_valid | input | 1 | Pixel strobe for the planes input |
| line_start | input | 1 | First pixel of a line, qualified by pix_valid |
| planes | input | 8 | Bitplane value of the pixel |
| pal_wr_en | input | 1 | Palette write strobe |
| pal_wr_addr | input | 8 | Palette entry to write |
| pal_wr_data | input | 24 | New palette entry, R/G/B packed |
| out_valid | output | 1 | Output pixel strobe |
| out_rgb | output | 24 | Output color, R/G/B packed |

## Verification
Some rules are checked on every cycle. Valid is delayed by exactly one clock and the output is steady while no pixel arrives. A modify pixel keeps two whole channels, and in wide mode all low bit pairs, from its predecessor. Narrow-mode output stays in the 12-bit space, and a palette write lands in the addressed entry. Other behaviour needs the directed scenarios. These are the exact fringing sequences, the channel that each control code selects, the index bits used in each mode, the line-start substitution of entry 0, and the ordering of a palette write against a pixel in the same cycle.

// File: rtl/ham_pkg.sv
package ham_pkg;

    localparam int CH_W       = 8;
    localparam int NARROW_W   = 4;
    localparam int WIDE_W     = 6;
    localparam int PLANES_W   = 8;
    localparam int KEEP_W     = CH_W - WIDE_W;
    localparam int RGB_W      = 3 * CH_W;
    localparam int NARROW_IDX = 5;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    typedef enum logic [1:0] {
        CTL_LOOKUP = 2'b00,
        CTL_MOD_B  = 2'b01,
        CTL_MOD_R  = 2'b10,
        CTL_MOD_G  = 2'b11
    } ctl_e;

    function automatic logic [CH_W-1:0] rep_nib(input logic [CH_W-1:0] ch);
        return {ch[CH_W-1 -: NARROW_W], ch[CH_W-1 -: NARROW_W]};
    endfunction

    function automatic rgb_t fold12(input rgb_t c);
        rgb_t f;
        f.r = rep_nib(c.r);
        f.g = rep_nib(c.g);
        f.b = rep_nib(c.b);
        return f;
    endfunction

endpackage

// File: rtl/ham_palette.sv
module ham_palette
    import ham_pkg::*;
#(
    parameter int ENTRIES = 256,
    localparam int ADDR_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  rgb_t              wr_data,
    input  logic [ADDR_W-1:0] rd_idx,
    output rgb_t              rd_data,
    output rgb_t              base_data
);

    rgb_t ent_q [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        rgb_t ent_d;

        always_comb begin
            ent_d = ent_q[i];
            if (wr_en && (wr_addr == ADDR_W'(i))) begin
                ent_d = wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[i] <= '0;
            end else begin
                ent_q[i] <= ent_d;
            end
        end
    end

    assign rd_data   = ent_q[rd_idx];
    assign base_data = ent_q[0];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ent_q[$past(wr_addr)] == $past(wr_data))); // R8

endmodule

// File: rtl/ham_index_sel.sv
module ham_index_sel
    import ham_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [PLANES_W-1:0] planes,
    input  logic                wide_mode,
    input  logic                ham_en,
    output logic [ADDR_W-1:0]   pal_idx,
    output ctl_e                ctl,
    output logic [WIDE_W-1:0]   mod_data
);

    always_comb begin
        pal_idx  = '0;
        ctl      = CTL_LOOKUP;
        mod_data = '0;
        unique case ({ham_en, wide_mode})
            2'b00: begin
                pal_idx = ADDR_W'(planes[NARROW_IDX-1:0]);
            end
            2'b01: begin
                pal_idx = ADDR_W'(planes);
            end
            2'b10: begin
                ctl      = ctl_e'(planes[NARROW_W+1:NARROW_W]);
                pal_idx  = ADDR_W'(planes[NARROW_W-1:0]);
                mod_data = WIDE_W'(planes[NARROW_W-1:0]);
            end
            default: begin
                ctl      = ctl_e'(planes[PLANES_W-1:PLANES_W-2]);
                pal_idx  = ADDR_W'(planes[WIDE_W-1:0]);
                mod_data = planes[WIDE_W-1:0];
            end
        endcase
    end

endmodule

// File: rtl/ham_color_calc.sv
module ham_color_calc
    import ham_pkg::*;
(
    input  logic              wide_mode,
    input  ctl_e              ctl,
    input  logic [WIDE_W-1:0] mod_data,
    input  rgb_t              pal_data,
    input  rgb_t              prev,
    output rgb_t              color
);

    rgb_t            base;
    rgb_t            lookup;
    logic [CH_W-1:0] mod_b;
    logic [CH_W-1:0] mod_r;
    logic [CH_W-1:0] mod_g;

    always_comb begin
        base   = wide_mode ? prev     : fold12(prev);
        lookup = wide_mode ? pal_data : fold12(pal_data);

        if (wide_mode) begin
            mod_b = {mod_data, base.b[KEEP_W-1:0]};
            mod_r = {mod_data, base.r[KEEP_W-1:0]};
            mod_g = {mod_data, base.g[KEEP_W-1:0]};
        end else begin
            mod_b = {mod_data[NARROW_W-1:0], mod_data[NARROW_W-1:0]};
            mod_r = mod_b;
            mod_g = mod_b;
        end

        color = base;
        unique case (ctl)
            CTL_LOOKUP: color   = lookup;
            CTL_MOD_B:  color.b = mod_b;
            CTL_MOD_R:  color.r = mod_r;
            default:    color.g = mod_g;
        endcase
    end

endmodule

// File: rtl/ham_pixel_decoder.sv
module ham_pixel_decoder
    import ham_pkg::*;
#(
    parameter int PAL_ENTRIES = 256,
    localparam int ADDR_W     = $clog2(PAL_ENTRIES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wide_mode,
    input  logic                ham_en,
    input  logic                pix_valid,
    input  logic                line_start,
    input  logic [PLANES_W-1:0] planes,
    input  logic                pal_wr_en,
    input  logic [ADDR_W-1:0]   pal_wr_addr,
    input  logic [RGB_W-1:0]    pal_wr_data,
    output logic                out_valid,
    output logic [RGB_W-1:0]    out_rgb
);

    typedef struct packed {
        logic vld;
        rgb_t rgb;
    } st_t;

    st_t               st_d;
    st_t               st_q;
    logic [ADDR_W-1:0] pal_idx;
    ctl_e              ctl;
    logic [WIDE_W-1:0] mod_data;
    rgb_t              pal_rd;
    rgb_t              pal_base;
    rgb_t              prev;
    rgb_t              color;

    ham_index_sel #(.ADDR_W(ADDR_W)) i_index_sel (
        .planes    (planes),
        .wide_mode (wide_mode),
        .ham_en    (ham_en),
        .pal_idx   (pal_idx),
        .ctl       (ctl),
        .mod_data  (mod_data)
    );

    ham_palette #(.ENTRIES(PAL_ENTRIES)) i_palette (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (pal_wr_en),
        .wr_addr   (pal_wr_addr),
        .wr_data   (rgb_t'(pal_wr_data)),
        .rd_idx    (pal_idx),
        .rd_data   (pal_rd),
        .base_data (pal_base)
    );

    ham_color_calc i_color_calc (
        .wide_mode (wide_mode),
        .ctl       (ctl),
        .mod_data  (mod_data),
        .pal_data  (pal_rd),
        .prev      (prev),
        .color     (color)
    );

    always_comb begin
        prev     = line_start ? pal_base : st_q.rgb;
        st_d     = st_q;
        st_d.vld = pix_valid;
        if (pix_valid) begin
            st_d.rgb = color;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_rgb   = st_q.rgb;

    rgb_t chk_prev;
    rgb_t chk_out;
    assign chk_prev = wide_mode ? prev : fold12(prev);
    assign chk_out  = rgb_t'(out_rgb);

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> out_valid); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> (!out_valid && $stable(out_rgb))); // R9

    AST_MOD_HOLDS_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && ham_en && ctl != CTL_LOOKUP) |=>
        (($past(ctl) == CTL_MOD_B && chk_out.r == $past(chk_prev.r) && chk_out.g == $past(chk_prev.g)) ||
         ($past(ctl) == CTL_MOD_R && chk_out.g == $past(chk_prev.g) && chk_out.b == $past(chk_prev.b)) ||
         ($past(ctl) == CTL_MOD_G && chk_out.r == $past(chk_prev.r) && chk_out.b == $past(chk_prev.b)))); // R5

    AST_WIDE_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && ham_en && wide_mode && ctl != CTL_LOOKUP) |=>
        (chk_out.r[KEEP_W-1:0] == $past(prev.r[KEEP_W-1:0]) &&
         chk_out.g[KEEP_W-1:0] == $past(prev.g[KEEP_W-1:0]) &&
         chk_out.b[KEEP_W-1:0] == $past(prev.b[KEEP_W-1:0]))); // R6

    AST_NARROW_12BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !wide_mode) |=> (chk_out == fold12(chk_out))); // R10

endmodule

// File: tb/test_ham_pixel_decoder.sv
`timescale 1ns/1ps
module test_ham_pixel_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b0;
    logic        ham_en = 1'b0;
    logic        pix_valid = 1'b0;
    logic        line_start = 1'b0;
    logic [7:0]  planes = '0;
    logic        pal_wr_en = 1'b0;
    logic [7:0]  pal_wr_addr = '0;
    logic [23:0] pal_wr_data = '0;
    logic        out_valid;
    logic [23:0] out_rgb;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [23:0] pal_m [256];
    logic [23:0] held_m = '0;

    always #2.5 clk = ~clk;

    ham_pixel_decoder i_ham_pixel_decoder (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .ham_en(ham_en),
        .pix_valid(pix_valid), .line_start(line_start), .planes(planes),
        .pal_wr_en(pal_wr_en), .pal_wr_addr(pal_wr_addr), .pal_wr_data(pal_wr_data),
        .out_valid(out_valid), .out_rgb(out_rgb)
    );

    task automatic check(input string req, input string what, input logic [23:0] act, input logic [23:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] f12(input logic [23:0] c);
        return {c[23:20], c[23:20], c[15:12], c[15:12], c[7:4], c[7:4]};
    endfunction

    // Reference from the requirements: R3..R7
    function automatic logic [23:0] model(input logic [7:0] p, input logic ls);
        logic [23:0] pv, c;
        logic [1:0]  code;
        logic [5:0]  d;
        pv = ls ? pal_m[0] : held_m;
        if (!wide_mode) pv = f12(pv);
        if (!ham_en) begin
            c = wide_mode ? pal_m[p] : f12(pal_m[{3'b000, p[4:0]}]);
        end else begin
            code = wide_mode ? p[7:6] : p[5:4];
            d    = wide_mode ? p[5:0] : {2'b00, p[3:0]};
            c    = pv;
            if (code == 2'b00) begin
                c = wide_mode ? pal_m[{2'b00, p[5:0]}] : f12(pal_m[{4'h0, p[3:0]}]);
            end else begin
                logic [7:0] ch;
                case (code)
                    2'b01:   ch = pv[7:0];
                    2'b10:   ch = pv[23:16];
                    default: ch = pv[15:8];
                endcase
                ch = wide_mode ? {d, ch[1:0]} : {d[3:0], d[3:0]};
                case (code)
                    2'b01:   c[7:0]   = ch;
                    2'b10:   c[23:16] = ch;
                    default: c[15:8]  = ch;
                endcase
            end
        end
        held_m = c;
        return c;
    endfunction

    task automatic set_mode(input logic w, input logic h);
        @(negedge clk);
        wide_mode = w;
        ham_en    = h;
    endtask

    task automatic pal_write(input logic [7:0] a, input logic [23:0] v);
        @(negedge clk);
        pal_wr_en = 1'b1; pal_wr_addr = a; pal_wr_data = v;
        @(negedge clk);
        pal_wr_en = 1'b0;
        pal_m[a] = v;
    endtask

    task automatic pixel(input logic [7:0] p, input logic ls, input string req);
        logic [23:0] e;
        @(negedge clk);
        pix_valid = 1'b1; planes = p; line_start = ls;
        e = model(p, ls);
        @(negedge clk);
        pix_valid = 1'b0; line_start = 1'b0;
        check(req, "out_valid", {23'd0, out_valid}, 24'd1);
        check(req, "out_rgb", out_rgb, e);
    endtask

    task automatic t_reset;
        check("R1", "out_valid after reset", {23'd0, out_valid}, 24'd0);
        check("R1", "out_rgb after reset", out_rgb, 24'd0);
        set_mode(1'b1, 1'b0);
        pixel(8'hAB, 1'b0, "R1");
    endtask

    task automatic t_indexed;
        pal_write(8'hC7, 24'h12_9A_F3);
        pal_write(8'h07, 24'h5E_6F_70);
        set_mode(1'b1, 1'b0);
        pixel(8'hC7, 1'b0, "R3");
        pixel(8'h07, 1'b0, "R3");
        set_mode(1'b0, 1'b0);
        pixel(8'hE7, 1'b0, "R3"); // bits 7:5 ignored, entry 7 folded
        check("R10", "narrow fold", out_rgb, 24'h55_66_77);
    endtask

    task automatic t_ham6;
        pal_write(8'h00, 24'h10_20_30);
        pal_write(8'h03, 24'hF0_00_00);
        set_mode(1'b0, 1'b1);
        pixel(8'h00, 1'b0, "R4");
        pixel(8'h2F, 1'b0, "R5"); // modify red
        pixel(8'h38, 1'b0, "R5"); // modify green
        pixel(8'h14, 1'b0, "R5"); // modify blue
        check("R5", "fringe result", out_rgb, 24'hFF_88_44);
        pixel(8'h03, 1'b0, "R4");
        check("R10", "lookup folded", out_rgb, 24'hFF_00_00);
    endtask

    task automatic t_ham8;
        pal_write(8'h05, 24'h8D_4E_27);
        set_mode(1'b1, 1'b1);
        pixel(8'h05, 1'b0, "R4");
        pixel(8'h7F, 1'b0, "R6");
        pixel(8'h80, 1'b0, "R6");
        pixel(8'hEA, 1'b0, "R6");
        check("R6", "low bits kept", out_rgb, 24'h01_AA_FF);
    endtask

    task automatic t_line_start;
        set_mode(1'b1, 1'b1);
        pixel(8'h05, 1'b0, "R7");
        pixel(8'hBF, 1'b1, "R7"); // modify red at line start
        check("R7", "entry 0 as predecessor", out_rgb, 24'hFC_20_30);
        set_mode(1'b0, 1'b1);
        pixel(8'h05, 1'b0, "R7");
        pixel(8'h1C, 1'b1, "R7");
        check("R7", "narrow line start", out_rgb, 24'h11_22_CC);
    endtask

    task automatic t_write_order;
        logic [23:0] old_v;
        set_mode(1'b1, 1'b0);
        old_v = pal_m[9];
        @(negedge clk);
        pal_wr_en = 1'b1; pal_wr_addr = 8'h09; pal_wr_data = 24'hA5_5A_C3;
        pix_valid = 1'b1; planes = 8'h09; line_start = 1'b0;
        @(negedge clk);
        pal_wr_en = 1'b0;
        check("R8", "same-cycle pixel sees old", out_rgb, old_v);
        pal_m[9] = 24'hA5_5A_C3;
        @(negedge clk);
        pix_valid = 1'b0;
        check("R8", "next pixel sees new", out_rgb, 24'hA5_5A_C3);
        held_m = 24'hA5_5A_C3;
    endtask

    task automatic t_gap;
        logic [23:0] keep;
        set_mode(1'b1, 1'b1);
        pixel(8'h05, 1'b0, "R9");
        pixel(8'h41, 1'b0, "R9");
        keep = out_rgb;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R2", "idle out_valid", {23'd0, out_valid}, 24'd0);
            check("R9", "idle holds rgb", out_rgb, keep);
        end
        pixel(8'hC2, 1'b0, "R9");
        check("R9", "modify after gap", out_rgb, 24'h8D_0A_07);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) pal_m[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_indexed();
        t_ham6();
        t_ham8();
        t_line_start();
        t_write_order();
        t_gap();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule